// File: doc/BRIEF.md
# Bit-Sliced Differential Partial-Sum Combiner

This block rebuilds signed dot-product results from digitized readings of a weight array that is driven one input slice at a time. Each 8-bit input activation reaches the array as two 4-bit slices in consecutive steps. The array keeps positive and negative weights in separate arrays. For every slice it returns, per output column, one 8-bit unsigned conversion code from the positive side and one from the negative side. The block subtracts the two codes in each column to get a signed slice result. It holds the result of the high slice and, when the matching low slice arrives, forms `(high << 4) + low`. The sum is rescaled by an arithmetic right shift with rounding and clamped to a signed 8-bit output activation. All columns are processed in parallel.

Codes enter over a valid/ready stream in which each beat carries every column and a flag that says whether the beat is the high or the low slice. A beat transfers on a clock edge where `in_valid` and `in_ready` are both 1. Results leave over a second valid/ready stream. While `out_valid` is 1 and `out_ready` is 0, the held result does not change and `in_ready` is 0, so back-pressure stops the input as well. Otherwise `in_ready` is 1. A low slice with no high slice pending is reported on a plain one-cycle error pin and is otherwise dropped.

Top module: `slice_diff_combiner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0, `slice_err` is 0 and `in_ready` is 1.
- R2: The slice result of a column is its positive code minus its negative code, taken as a signed value in the range -255 to 255.
- R3: Beats marked `in_hi`=1 are the high slice and beats marked `in_hi`=0 are the low slice. The combined value of a column is the pending high slice result times 16 plus the low slice result. Column c occupies bits [8c+7:8c] of the code and result buses.
- R4: The combined value is scaled as floor((v + 8) / 16), which is a right shift by 4 that rounds halves toward positive infinity.
- R5: A scaled value above 127 gives 127, and one below -128 gives -128. The result is two's complement.
- R6: The cycle after a low slice is accepted with a high slice pending, `out_valid` is 1 and `out_data` holds the result. The pending high slice is then consumed.
- R7: A low slice accepted with no high slice pending makes `slice_err` 1 for exactly the next cycle and produces no result.
- R8: A second high slice accepted before any low slice replaces the pending one.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold and `in_ready` is 0. Otherwise `in_ready` is 1.
- R10: Accepting a high slice never produces a result. The cycle after it, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can accept a beat |
| in_hi | input | 1 | 1 = high slice, 0 = low slice |
| in_pos | input | COLS*8 | Positive-array codes, one byte per column |
| in_neg | input | COLS*8 | Negative-array codes, one byte per column |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | COLS*8 | Signed results, one byte per column |
| slice_err | output | 1 | One-cycle pulse for an orphan low slice |

## Verification
The hardest state to reach from the ports is the collision between ordering and flow control. This means a low slice arriving exactly when the output register is being drained, or a low slice that finds its high slice was already consumed or replaced. Random traffic mixes the slice flag freely with a randomly toggled `out_ready`, so orphan low slices, repeated high slices and stalled results all happen next to each other. A behavioural model predicts every output on every cycle. Directed vectors drive the rounding midpoints and both saturation limits.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic {
    SLICE_LO = 1'b0,
    SLICE_HI = 1'b1
  } slice_e;
endpackage

// File: rtl/sdc_col_diff.sv
module sdc_col_diff #(
  parameter int CODE_W = 8,
  localparam int DIFF_W = CODE_W + 1
) (
  input  logic [CODE_W-1:0]        pos_code,
  input  logic [CODE_W-1:0]        neg_code,
  output logic signed [DIFF_W-1:0] diff
);
  always_comb begin
    diff = $signed({1'b0, pos_code}) - $signed({1'b0, neg_code});
  end
endmodule

// File: rtl/sdc_slice_track.sv
module sdc_slice_track
  import sdc_pkg::*;
#(
  parameter int COLS   = 4,
  parameter int DIFF_W = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take,
  input  logic                   is_hi,
  input  logic [COLS*DIFF_W-1:0] diffs,
  output logic                   pending,
  output logic [COLS*DIFF_W-1:0] hi_diffs,
  output logic                   fire,
  output logic                   err
);
  slice_e kind;
  logic   orphan;

  assign kind   = slice_e'(is_hi);
  assign fire   = take && (kind == SLICE_LO) && pending;
  assign orphan = take && (kind == SLICE_LO) && !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      hi_diffs <= '0;
      err      <= 1'b0;
    end else begin
      err <= orphan;
      if (take) begin
        case (kind)
          SLICE_HI: begin
            pending  <= 1'b1;
            hi_diffs <= diffs;
          end
          default: pending <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdc_col_merge.sv
module sdc_col_merge #(
  parameter int DIFF_W  = 9,
  parameter int SLICE_W = 4,
  parameter int RSHIFT  = 4,
  parameter int OUT_W   = 8,
  localparam int COMB_W = DIFF_W + SLICE_W + 1,
  localparam int RND_W  = COMB_W + 1
) (
  input  logic signed [DIFF_W-1:0] hi_diff,
  input  logic signed [DIFF_W-1:0] lo_diff,
  output logic signed [OUT_W-1:0]  result
);
  localparam logic signed [RND_W-1:0] MAXV = RND_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [RND_W-1:0] MINV = -MAXV - RND_W'(1);

  logic signed [COMB_W-1:0] hi_x, lo_x, comb;
  logic signed [RND_W-1:0]  scaled;

  assign hi_x = {{(COMB_W-DIFF_W){hi_diff[DIFF_W-1]}}, hi_diff};
  assign lo_x = {{(COMB_W-DIFF_W){lo_diff[DIFF_W-1]}}, lo_diff};
  assign comb = (hi_x <<< SLICE_W) + lo_x;

  generate
    if (RSHIFT > 0) begin : g_round
      localparam logic signed [RND_W-1:0] HALF = RND_W'(1) <<< (RSHIFT - 1);
      logic signed [RND_W-1:0] biased;
      assign biased = {comb[COMB_W-1], comb} + HALF;
      assign scaled = biased >>> RSHIFT;
    end else begin : g_pass
      assign scaled = {comb[COMB_W-1], comb};
    end
  endgenerate

  always_comb begin
    if (scaled > MAXV)      result = MAXV[OUT_W-1:0];
    else if (scaled < MINV) result = MINV[OUT_W-1:0];
    else                    result = scaled[OUT_W-1:0];
  end
endmodule

// File: rtl/slice_diff_combiner.sv
module slice_diff_combiner #(
  parameter int COLS    = 4,
  parameter int CODE_W  = 8,
  parameter int SLICE_W = 4,
  parameter int RSHIFT  = 4,
  parameter int OUT_W   = 8,
  localparam int DIFF_W = CODE_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_hi,
  input  logic [COLS*CODE_W-1:0] in_pos,
  input  logic [COLS*CODE_W-1:0] in_neg,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [COLS*OUT_W-1:0]  out_data,
  output logic                   slice_err
);
  logic                   accept;
  logic                   hi_pending;
  logic                   fire;
  logic [COLS*DIFF_W-1:0] cur_diffs;
  logic [COLS*DIFF_W-1:0] held_diffs;
  logic [COLS*OUT_W-1:0]  merged;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  generate
    for (genvar c = 0; c < COLS; c++) begin : g_col
      sdc_col_diff #(.CODE_W(CODE_W)) u_diff (
        .pos_code (in_pos[c*CODE_W +: CODE_W]),
        .neg_code (in_neg[c*CODE_W +: CODE_W]),
        .diff     (cur_diffs[c*DIFF_W +: DIFF_W])
      );
      sdc_col_merge #(
        .DIFF_W(DIFF_W), .SLICE_W(SLICE_W), .RSHIFT(RSHIFT), .OUT_W(OUT_W)
      ) u_merge (
        .hi_diff (held_diffs[c*DIFF_W +: DIFF_W]),
        .lo_diff (cur_diffs[c*DIFF_W +: DIFF_W]),
        .result  (merged[c*OUT_W +: OUT_W])
      );
    end
  endgenerate

  sdc_slice_track #(.COLS(COLS), .DIFF_W(DIFF_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (accept),
    .is_hi    (in_hi),
    .diffs    (cur_diffs),
    .pending  (hi_pending),
    .hi_diffs (held_diffs),
    .fire     (fire),
    .err      (slice_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= merged;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_hi,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              slice_err,
  input logic              hi_pending
);
  // R6
  low_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_hi && hi_pending) |=> (out_valid && !slice_err));

  // R7
  orphan_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_hi && !hi_pending) |=> slice_err);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slice_err |-> $past(in_valid && in_ready && !in_hi && !hi_pending));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  hi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_hi) |=> !out_valid);
endmodule

bind slice_diff_combiner sdc_checker #(.DATA_W(COLS*OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_hi      (in_hi),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .slice_err  (slice_err),
  .hi_pending (hi_pending)
);

// File: tb/slice_diff_combiner_test.sv
`timescale 1ns/1ps
module slice_diff_combiner_test;
  localparam int COLS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_hi = 1'b0;
  logic [COLS*8-1:0] in_pos = '0;
  logic [COLS*8-1:0] in_neg = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, slice_err;
  logic [COLS*8-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slice_diff_combiner uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hi(in_hi), .in_pos(in_pos), .in_neg(in_neg), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .slice_err(slice_err)
  );

  // behavioural reference model
  bit m_valid = 0, m_err = 0, m_pend = 0;
  int m_hi[COLS];
  int m_out[COLS];

  function automatic int expect_col(int h, int l);
    int v;
    v = (h * 16 + l + 8) >>> 4;
    if (v > 127) v = 127;
    if (v < -128) v = -128;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_err = 0; m_pend = 0;
    end else begin
      bit rdy;
      rdy = !m_valid || out_ready;
      m_err = 0;
      if (m_valid && out_ready) m_valid = 0;
      if (in_valid && rdy) begin
        if (in_hi) begin
          m_pend = 1;
          for (int c = 0; c < COLS; c++)
            m_hi[c] = int'(in_pos[c*8 +: 8]) - int'(in_neg[c*8 +: 8]);
        end else if (m_pend) begin
          for (int c = 0; c < COLS; c++)
            m_out[c] = expect_col(m_hi[c], int'(in_pos[c*8 +: 8]) - int'(in_neg[c*8 +: 8]));
          m_valid = 1;
          m_pend = 0;
        end else begin
          m_err = 1;
        end
      end
    end
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  function automatic int col_out(int c);
    return int'($signed(out_data[c*8 +: 8]));
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 out_valid", int'(out_valid), int'(m_valid));
      chk("R7 slice_err", int'(slice_err), int'(m_err));
      chk("R9 in_ready", int'(in_ready), int'(!m_valid || out_ready));
      if (m_valid)
        for (int c = 0; c < COLS; c++) chk("R3 out_data column", col_out(c), m_out[c]);
    end
  end

  task automatic send(bit hi, int p[COLS], int n[COLS]);
    in_valid = 1'b1;
    in_hi = hi;
    for (int c = 0; c < COLS; c++) begin
      in_pos[c*8 +: 8] = 8'(p[c]);
      in_neg[c*8 +: 8] = 8'(n[c]);
    end
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int z[COLS] = '{0, 0, 0, 0};
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 slice_err in reset", int'(slice_err), 0);
    chk("R1 in_ready in reset", int'(in_ready), 1);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 in_ready after reset", int'(in_ready), 1);
    @(posedge clk); #2;

    // orphan low slice right after reset
    send(1'b0, '{9, 9, 9, 9}, z);
    @(negedge clk);
    chk("R7 orphan pulse", int'(slice_err), 1);
    chk("R7 no result", int'(out_valid), 0);
    @(negedge clk);
    chk("R7 pulse one cycle", int'(slice_err), 0);
    @(posedge clk); #2;

    // high slice alone yields nothing
    send(1'b1, '{0, 255, 0, 10}, '{0, 0, 255, 0});
    @(negedge clk);
    chk("R10 high gives no output", int'(out_valid), 0);
    @(posedge clk); #2;
    send(1'b0, '{8, 255, 0, 7}, '{0, 0, 255, 0});
    @(negedge clk);
    chk("R6 valid after low", int'(out_valid), 1);
    chk("R4 round half up col0", col_out(0), 1);
    chk("R5 clamp high col1", col_out(1), 127);
    chk("R5 clamp low col2", col_out(2), -128);
    chk("R3 combine col3", col_out(3), 10);
    @(posedge clk); #2;

    send(1'b1, '{0, 0, 0, 1}, '{0, 0, 0, 0});
    send(1'b0, '{0, 0, 7, 0}, '{9, 8, 0, 0});
    @(negedge clk);
    chk("R4 round -9 col0", col_out(0), -1);
    chk("R4 round -8 col1", col_out(1), 0);
    chk("R4 round 7 col2", col_out(2), 0);
    chk("R10 columns independent col3", col_out(3), 1);
    @(posedge clk); #2;

    // R2 signed difference
    send(1'b1, '{3, 200, 0, 0}, '{5, 100, 0, 0});
    send(1'b0, z, z);
    @(negedge clk);
    chk("R2 negative difference col0", col_out(0), -2);
    chk("R2 positive difference col1", col_out(1), 100);
    @(posedge clk); #2;

    // R8 replacement
    send(1'b1, '{100, 0, 0, 0}, z);
    send(1'b1, '{2, 0, 0, 0}, z);
    send(1'b0, z, z);
    @(negedge clk);
    chk("R8 second high wins", col_out(0), 2);
    @(posedge clk); #2;

    // R9 back-pressure
    out_ready = 1'b0;
    send(1'b1, '{50, 0, 0, 0}, z);
    send(1'b0, '{4, 0, 0, 0}, z);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 held valid", int'(out_valid), 1);
      chk("R9 held data", col_out(0), 50);
      chk("R9 input stalled", int'(in_ready), 0);
    end
    @(posedge clk); #2; out_ready = 1'b1;
    @(negedge clk);
    @(posedge clk); #2;

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      in_valid  = ($urandom_range(0, 3) != 0);
      in_hi     = ($urandom_range(0, 1) == 1);
      in_pos    = COLS*8'($urandom());
      in_neg    = COLS*8'($urandom());
      out_ready = ($urandom_range(0, 3) != 0);
      @(posedge clk); #2;
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule